// File: doc/BRIEF.md
# Configuration Address and Data Port Bridge

This block sits between a processor's memory-mapped register bus and a configuration-space target. Software first writes a 32-bit tag into an address port. The block keeps that raw tag and decodes it into a bus, device, function and register tuple. A later access to a separate data port becomes one configuration request to the target, carrying that tuple. The processor's response is held back until the target acknowledges.

Two tag layouts are understood, and bit 0 of the tag selects between them. With bit 0 set, the fields are binary and bit 0 is cleared before decoding. With bit 0 clear, the tag names the device by one set bit in positions 11 to 31, and the bus number is zero. A one-hot tag with no set bit in that range sets an error flag. While the error flag is set, data-port accesses are answered locally and never reach the target. Writing zero to the address port clears the stored tag but keeps the previously decoded tuple.

Top module: `cfg_host_port`

## Requirements
- R1: After reset, the stored tag reads back as 0, the decoded tuple (bus, device, function, register) is all zero, errFlag is 0, and neither cfgReq nor cpuReady is asserted.
- R2: The address port is at byte offset 0x800000 and must be accessed aligned. It uses byte lanes 0 to 3, little-endian (lane n is cpuWdata bits 8n+7:8n), and a write updates only the lanes whose cpuBe bit is set. A read returns the last raw stored tag in lanes 0 to 3 and zero in lanes 4 to 7. An address-port access sets cpuReady for one cycle, in the cycle after the access is accepted.
- R3: A nonzero tag with bit 0 = 1 decodes as bus = bits 23:16, device = bits 15:11, function = bits 10:8, register = bits 7:0 with bit 0 forced to 0, and it clears errFlag.
- R4: A nonzero tag with bit 0 = 0 decodes as bus = 0, device = the index of the lowest set bit among bits 31:11, function = bits 10:8, register = bits 7:0, and it clears errFlag.
- R5: A nonzero tag with bit 0 = 0 and bits 31:11 all zero sets errFlag. While errFlag is set, a data-port access raises no cfgReq. A read returns all ones and a write is dropped.
- R6: Writing a tag that is 0 after the byte-lane merge stores 0 but does no decode. The decoded tuple and errFlag keep their previous values.
- R7: The data port is at byte offset 0xC00000 and must be accessed aligned, using all 8 byte lanes. When errFlag is clear, each access raises cfgReq for exactly one transaction, carrying the decoded tuple, cpuBe, the write flag and the write data. cfgReq stays high until cfgAck and is low in the cycle after the cfgAck edge.
- R8: For a data-port access, cpuReady is withheld until the target acknowledges. It is high for exactly the one cycle after the cfgAck edge. A read returns the cfgRdata captured at that edge, and a write returns 0.
- R9: An access to any other offset, including a misaligned one, returns 0 after one cycle, raises no cfgReq and changes neither the stored tag nor the decoded tuple.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor access pending; held until cpuReady |
| cpuAddr | input | 24 | Byte offset from the bridge base |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuBe | input | 8 | Byte-lane enables, lane 0 least significant |
| cpuWdata | input | 64 | Write data, little-endian lanes |
| cpuRdata | output | 64 | Read data, valid while cpuReady |
| cpuReady | output | 1 | One-cycle completion of the access |
| cfgReq | output | 1 | Configuration request, held until cfgAck |
| cfgWrite | output | 1 | Request is a write |
| cfgBus | output | 8 | Decoded bus number |
| cfgDev | output | 5 | Decoded device number |
| cfgFunc | output | 3 | Decoded function number |
| cfgReg | output | 8 | Decoded register offset |
| cfgBe | output | 8 | Byte enables of the request |
| cfgWdata | output | 64 | Write data of the request |
| cfgAck | input | 1 | Target acknowledge |
| cfgRdata | input | 64 | Target read data, sampled with cfgAck |
| errFlag | output | 1 | Last decoded one-hot tag named no device |

## Verification
The bench targets the priority choice among several set device bits and the two ends of that range, bit 11 and bit 31. An encoder that picks the highest bit, or that is off by one at either end, reports the wrong device. It checks that a one-hot tag forces bus 0 right after a binary tag with a nonzero bus, which catches a design that keeps the old bus. It also writes zero both after a good decode and while the error flag is set, to catch a decoder that runs on zero and wipes the tuple or the error. Partial byte-lane writes, offsets outside the two windows, and a target that delays its acknowledge check the lane merge, stray state updates, and a response sent too early or a request repeated.

// File: rtl/cfg_host_pkg.sv
package cfg_host_pkg;

  localparam int CPU_BYTES  = 8;
  localparam int CPU_DW     = CPU_BYTES * 8;
  localparam int TAG_BYTES  = 4;
  localparam int TAG_W      = TAG_BYTES * 8;
  localparam int BUS_W      = 8;
  localparam int DEV_W      = 5;
  localparam int FUNC_W     = 3;
  localparam int REG_W      = 8;
  localparam int DEV_LO     = 11;
  localparam int DEV_HI     = TAG_W - 1;
  localparam int FUNC_LO    = 8;
  localparam int BUS_LO     = 16;

  typedef enum logic [1:0] {
    RD_ZERO  = 2'd0,
    RD_TAG   = 2'd1,
    RD_CFG   = 2'd2,
    RD_ABORT = 2'd3
  } rdSrc_e;

  typedef struct packed {
    logic   tagWr;
    logic   reqLoad;
    logic   rdLoad;
    rdSrc_e rdSrc;
  } ctlStrobes_t;

endpackage

// File: rtl/cfg_host_dp.sv
module cfg_host_dp
  import cfg_host_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strb,
  input  logic                cpuWe,
  input  logic [CPU_BYTES-1:0] cpuBe,
  input  logic [CPU_DW-1:0]   cpuWdata,
  input  logic [CPU_DW-1:0]   cfgRdata,
  output logic [CPU_DW-1:0]   cpuRdata,
  output logic                cfgWrite,
  output logic [BUS_W-1:0]    cfgBus,
  output logic [DEV_W-1:0]    cfgDev,
  output logic [FUNC_W-1:0]   cfgFunc,
  output logic [REG_W-1:0]    cfgReg,
  output logic [CPU_BYTES-1:0] cfgBe,
  output logic [CPU_DW-1:0]   cfgWdata,
  output logic                errFlag
);

  logic [TAG_W-1:0]  tagReg;
  logic [TAG_W-1:0]  tagNext;
  logic [TAG_W-1:0]  tagClean;
  logic              binLayout;
  logic              tagIsZero;
  logic              devHit;
  logic [DEV_W-1:0]  devIdx;

  logic [BUS_W-1:0]  busReg;
  logic [DEV_W-1:0]  devReg;
  logic [FUNC_W-1:0] funcReg;
  logic [REG_W-1:0]  regReg;
  logic              errReg;

  logic [CPU_DW-1:0] rdReg;
  logic              wrReg;
  logic [CPU_BYTES-1:0] beReg;
  logic [CPU_DW-1:0] wdReg;

  // Byte-lane merge of the incoming tag onto the stored one
  for (genvar b = 0; b < TAG_BYTES; b++) begin : g_lane
    assign tagNext[8*b +: 8] = cpuBe[b] ? cpuWdata[8*b +: 8] : tagReg[8*b +: 8];
  end

  assign binLayout = tagNext[0];
  assign tagIsZero = (tagNext == '0);
  assign tagClean  = {tagNext[TAG_W-1:1], 1'b0};

  // Lowest set device-select bit wins: scan downward so the last hit is lowest
  always_comb begin
    devHit = 1'b0;
    devIdx = '0;
    for (int i = DEV_HI; i >= DEV_LO; i--) begin
      if (tagNext[i]) begin
        devHit = 1'b1;
        devIdx = DEV_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagReg  <= '0;
      busReg  <= '0;
      devReg  <= '0;
      funcReg <= '0;
      regReg  <= '0;
      errReg  <= 1'b0;
    end else if (strb.tagWr) begin
      tagReg <= tagNext;
      if (!tagIsZero) begin
        if (binLayout) begin
          busReg  <= tagClean[BUS_LO +: BUS_W];
          devReg  <= tagClean[DEV_LO +: DEV_W];
          funcReg <= tagClean[FUNC_LO +: FUNC_W];
          regReg  <= tagClean[0 +: REG_W];
          errReg  <= 1'b0;
        end else if (devHit) begin
          busReg  <= '0;
          devReg  <= devIdx;
          funcReg <= tagNext[FUNC_LO +: FUNC_W];
          regReg  <= tagNext[0 +: REG_W];
          errReg  <= 1'b0;
        end else begin
          errReg  <= 1'b1;
        end
      end
    end
  end

  // Request payload captured when the control launches a request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrReg <= 1'b0;
      beReg <= '0;
      wdReg <= '0;
    end else if (strb.reqLoad) begin
      wrReg <= cpuWe;
      beReg <= cpuBe;
      wdReg <= cpuWdata;
    end
  end

  // Response data register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdReg <= '0;
    end else if (strb.rdLoad) begin
      unique case (strb.rdSrc)
        RD_ZERO:  rdReg <= '0;
        RD_TAG:   rdReg <= {{(CPU_DW-TAG_W){1'b0}}, tagReg};
        RD_CFG:   rdReg <= cfgRdata;
        RD_ABORT: rdReg <= '1;
        default:  rdReg <= '0;
      endcase
    end
  end

  assign cpuRdata = rdReg;
  assign cfgWrite = wrReg;
  assign cfgBus   = busReg;
  assign cfgDev   = devReg;
  assign cfgFunc  = funcReg;
  assign cfgReg   = regReg;
  assign cfgBe    = beReg;
  assign cfgWdata = wdReg;
  assign errFlag  = errReg;

  AST_ZERO_KEEPS_TUPLE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tagWr && tagIsZero) |=> ($stable(busReg) && $stable(devReg) &&
      $stable(funcReg) && $stable(regReg) && $stable(errReg))); // R6

  AST_ONEHOT_BUS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tagWr && !tagNext[0] && (|tagNext[DEV_HI:DEV_LO])) |=> (cfgBus == '0)); // R4

  AST_BIN_REG_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tagWr && tagNext[0]) |=> (cfgReg[0] == 1'b0 && !errFlag)); // R3

  AST_ERR_NEEDS_TAG_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(strb.tagWr)); // R5

endmodule

// File: rtl/cfg_host_ctrl.sv
module cfg_host_ctrl
  import cfg_host_pkg::*;
#(
  parameter int          ADDR_W        = 24,
  parameter logic [ADDR_W-1:0] TAG_PORT_OFF  = 24'h800000,
  parameter logic [ADDR_W-1:0] DATA_PORT_OFF = 24'hC00000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWe,
  input  logic              cfgAck,
  input  logic              errFlag,
  output logic              cpuReady,
  output logic              cfgReq,
  output ctlStrobes_t       strb
);

  localparam int TAG_LSB  = $clog2(TAG_BYTES);
  localparam int DATA_LSB = $clog2(CPU_BYTES);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } state_e;

  state_e state;
  state_e stateNext;
  logic   hitTag;
  logic   hitData;

  assign hitTag  = (cpuAddr[ADDR_W-1:TAG_LSB]  == TAG_PORT_OFF[ADDR_W-1:TAG_LSB])
                 && (cpuAddr[TAG_LSB-1:0] == '0);
  assign hitData = (cpuAddr[ADDR_W-1:DATA_LSB] == DATA_PORT_OFF[ADDR_W-1:DATA_LSB])
                 && (cpuAddr[DATA_LSB-1:0] == '0);

  always_comb begin
    stateNext    = state;
    strb.tagWr   = 1'b0;
    strb.reqLoad = 1'b0;
    strb.rdLoad  = 1'b0;
    strb.rdSrc   = RD_ZERO;
    unique case (state)
      ST_IDLE: begin
        if (cpuValid) begin
          if (hitTag) begin
            strb.tagWr  = cpuWe;
            strb.rdLoad = 1'b1;
            strb.rdSrc  = cpuWe ? RD_ZERO : RD_TAG;
            stateNext   = ST_RESP;
          end else if (hitData && !errFlag) begin
            strb.reqLoad = 1'b1;
            stateNext    = ST_WAIT;
          end else if (hitData) begin
            strb.rdLoad = 1'b1;
            strb.rdSrc  = cpuWe ? RD_ZERO : RD_ABORT;
            stateNext   = ST_RESP;
          end else begin
            strb.rdLoad = 1'b1;
            strb.rdSrc  = RD_ZERO;
            stateNext   = ST_RESP;
          end
        end
      end
      ST_WAIT: begin
        if (cfgAck) begin
          strb.rdLoad = 1'b1;
          strb.rdSrc  = cpuWe ? RD_ZERO : RD_CFG;
          stateNext   = ST_RESP;
        end
      end
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign cfgReq   = (state == ST_WAIT);
  assign cpuReady = (state == ST_RESP);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReq && !cfgAck) |=> cfgReq); // R7

  AST_REQ_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReq && cfgAck) |=> !cfgReq); // R7

  AST_NO_REQ_ON_ERR: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq |-> !errFlag); // R5

  AST_READY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReq && cfgAck) |=> cpuReady); // R8

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady); // R8

  AST_NO_READY_IN_REQ: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq |-> !cpuReady); // R8

endmodule

// File: rtl/cfg_host_port.sv
module cfg_host_port
  import cfg_host_pkg::*;
#(
  parameter int          ADDR_W        = 24,
  parameter logic [ADDR_W-1:0] TAG_PORT_OFF  = 24'h800000,
  parameter logic [ADDR_W-1:0] DATA_PORT_OFF = 24'hC00000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cpuValid,
  input  logic [ADDR_W-1:0]    cpuAddr,
  input  logic                 cpuWe,
  input  logic [CPU_BYTES-1:0] cpuBe,
  input  logic [CPU_DW-1:0]    cpuWdata,
  output logic [CPU_DW-1:0]    cpuRdata,
  output logic                 cpuReady,
  output logic                 cfgReq,
  output logic                 cfgWrite,
  output logic [BUS_W-1:0]     cfgBus,
  output logic [DEV_W-1:0]     cfgDev,
  output logic [FUNC_W-1:0]    cfgFunc,
  output logic [REG_W-1:0]     cfgReg,
  output logic [CPU_BYTES-1:0] cfgBe,
  output logic [CPU_DW-1:0]    cfgWdata,
  input  logic                 cfgAck,
  input  logic [CPU_DW-1:0]    cfgRdata,
  output logic                 errFlag
);

  ctlStrobes_t strb;

  cfg_host_ctrl #(
    .ADDR_W        (ADDR_W),
    .TAG_PORT_OFF  (TAG_PORT_OFF),
    .DATA_PORT_OFF (DATA_PORT_OFF)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuValid (cpuValid),
    .cpuAddr  (cpuAddr),
    .cpuWe    (cpuWe),
    .cfgAck   (cfgAck),
    .errFlag  (errFlag),
    .cpuReady (cpuReady),
    .cfgReq   (cfgReq),
    .strb     (strb)
  );

  cfg_host_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cpuWe    (cpuWe),
    .cpuBe    (cpuBe),
    .cpuWdata (cpuWdata),
    .cfgRdata (cfgRdata),
    .cpuRdata (cpuRdata),
    .cfgWrite (cfgWrite),
    .cfgBus   (cfgBus),
    .cfgDev   (cfgDev),
    .cfgFunc  (cfgFunc),
    .cfgReg   (cfgReg),
    .cfgBe    (cfgBe),
    .cfgWdata (cfgWdata),
    .errFlag  (errFlag)
  );

endmodule

// File: tb/cfg_host_port_tb.sv
`timescale 1ns/1ps
module cfg_host_port_tb;

  localparam logic [23:0] TAG_OFF  = 24'h800000;
  localparam logic [23:0] DATA_OFF = 24'hC00000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuValid = 1'b0;
  logic [23:0] cpuAddr = '0;
  logic        cpuWe = 1'b0;
  logic [7:0]  cpuBe = '0;
  logic [63:0] cpuWdata = '0;
  logic [63:0] cpuRdata;
  logic        cpuReady;
  logic        cfgReq;
  logic        cfgWrite;
  logic [7:0]  cfgBus;
  logic [4:0]  cfgDev;
  logic [2:0]  cfgFunc;
  logic [7:0]  cfgReg;
  logic [7:0]  cfgBe;
  logic [63:0] cfgWdata;
  logic        cfgAck = 1'b0;
  logic [63:0] cfgRdata = '0;
  logic        errFlag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // results of the last access
  bit          reqSeen;
  int          reqAfterAck;
  int          ackCycle;
  int          readyCycle;
  logic [63:0] rdOut;
  logic        recWr;
  logic [7:0]  recBus;
  logic [4:0]  recDev;
  logic [2:0]  recFunc;
  logic [7:0]  recReg;
  logic [7:0]  recBe;
  logic [63:0] recWdata;

  always #2.5 clk = ~clk;

  cfg_host_port u_dut (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuAddr(cpuAddr),
    .cpuWe(cpuWe), .cpuBe(cpuBe), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .cpuReady(cpuReady), .cfgReq(cfgReq), .cfgWrite(cfgWrite), .cfgBus(cfgBus),
    .cfgDev(cfgDev), .cfgFunc(cfgFunc), .cfgReg(cfgReg), .cfgBe(cfgBe),
    .cfgWdata(cfgWdata), .cfgAck(cfgAck), .cfgRdata(cfgRdata), .errFlag(errFlag)
  );

  task automatic checkEq(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // One processor access with a target model that acks after ackDelay cycles
  task automatic doAccess(input logic [23:0] addr, input logic we, input logic [7:0] be,
                          input logic [63:0] wd, input logic [63:0] tgt, input int ackDelay);
    bit acked = 0;
    int waitCnt = 0;
    bool_done: begin end
    reqSeen = 0; reqAfterAck = 0; ackCycle = -1; readyCycle = -1; rdOut = 'x;
    @(negedge clk);
    cpuValid = 1'b1; cpuAddr = addr; cpuWe = we; cpuBe = be; cpuWdata = wd;
    for (int cyc = 1; cyc <= 60; cyc++) begin
      @(negedge clk);
      cfgAck = 1'b0;
      if (cpuReady) begin
        rdOut = cpuRdata;
        readyCycle = cyc;
        break;
      end
      if (cfgReq) begin
        if (acked) reqAfterAck++;
        else begin
          if (!reqSeen) begin
            reqSeen = 1;
            recWr = cfgWrite; recBus = cfgBus; recDev = cfgDev; recFunc = cfgFunc;
            recReg = cfgReg; recBe = cfgBe; recWdata = cfgWdata;
          end
          if (waitCnt == ackDelay) begin
            cfgAck = 1'b1; cfgRdata = tgt; acked = 1; ackCycle = cyc;
          end else waitCnt++;
        end
      end
    end
    cpuValid = 1'b0;
    if (readyCycle < 0) checkEq("R8 access never completed", 0, 1);
    @(negedge clk);
    checkEq("R8 ready is a single pulse", {63'b0, cpuReady}, 64'd0);
    checkEq("R7 request dropped after ack", {63'b0, cfgReq}, 64'd0);
  endtask

  task automatic wrTag(input logic [31:0] val, input logic [7:0] be);
    doAccess(TAG_OFF, 1'b1, be, {32'hDEAD_BEEF, val}, '0, 0);
  endtask

  task automatic rdTag(input string req, input logic [31:0] expVal);
    doAccess(TAG_OFF, 1'b0, 8'hFF, '0, '0, 0);
    checkEq(req, rdOut, {32'b0, expVal});
    checkEq("R2 tag port answers in one cycle", readyCycle, 1);
  endtask

  task automatic checkTuple(input string req, input logic [7:0] b, input logic [4:0] d,
                            input logic [2:0] f, input logic [7:0] r);
    doAccess(DATA_OFF, 1'b0, 8'hFF, '0, 64'h0123_4567_89AB_CDEF, 1);
    checkEq({req, " request raised"}, {63'b0, reqSeen}, 64'd1);
    checkEq({req, " bus"}, recBus, b);
    checkEq({req, " device"}, recDev, d);
    checkEq({req, " function"}, recFunc, f);
    checkEq({req, " register"}, recReg, r);
  endtask

  task automatic t_reset();
    checkEq("R1 errFlag after reset", {63'b0, errFlag}, 0);
    checkEq("R1 cfgReq after reset", {63'b0, cfgReq}, 0);
    checkEq("R1 cpuReady after reset", {63'b0, cpuReady}, 0);
    rdTag("R1 stored tag after reset", 32'h0);
    checkTuple("R1 tuple after reset", 8'h0, 5'd0, 3'd0, 8'h0);
  endtask

  task automatic t_binary();
    wrTag(32'h00AB_5AC5, 8'h0F);
    rdTag("R2 raw tag readback", 32'h00AB_5AC5);
    checkEq("R3 errFlag clear", {63'b0, errFlag}, 0);
    doAccess(DATA_OFF, 1'b0, 8'h0F, '0, 64'h1122_3344_5566_7788, 2);
    checkEq("R3 bus", recBus, 8'hAB);
    checkEq("R3 device", recDev, 5'd11);
    checkEq("R3 function", recFunc, 3'd2);
    checkEq("R3 register bit0 cleared", recReg, 8'hC4);
    checkEq("R7 byte enables", recBe, 8'h0F);
    checkEq("R7 read flag", {63'b0, recWr}, 0);
    checkEq("R8 read data from target", rdOut, 64'h1122_3344_5566_7788);
    checkEq("R8 ready one cycle after ack", readyCycle, ackCycle + 1);
    checkEq("R7 no second request", reqAfterAck, 0);
  endtask

  task automatic t_partial();
    // lane 1 and lane 4 enabled; lane 4 lies outside the tag port
    doAccess(TAG_OFF, 1'b1, 8'h12, 64'h0000_00EE_0000_1900, '0, 0);
    rdTag("R2 byte-lane merge", 32'h00AB_19C5);
    checkTuple("R3 after merge", 8'hAB, 5'd3, 3'd1, 8'hC4);
  endtask

  task automatic t_onehot();
    wrTag(32'h0012_053C, 8'h0F);
    doAccess(DATA_OFF, 1'b1, 8'hF0, 64'hCAFE_F00D_1234_5678, 64'hFFFF, 0);
    checkEq("R4 bus forced to zero", recBus, 8'h00);
    checkEq("R4 lowest device bit", recDev, 5'd17);
    checkEq("R4 function", recFunc, 3'd5);
    checkEq("R4 register", recReg, 8'h3C);
    checkEq("R7 write flag", {63'b0, recWr}, 1);
    checkEq("R7 write byte enables", recBe, 8'hF0);
    checkEq("R7 write data", recWdata, 64'hCAFE_F00D_1234_5678);
    checkEq("R8 write returns zero", rdOut, 64'h0);
    wrTag(32'h8000_0008, 8'h0F);
    checkTuple("R4 top device bit", 8'h0, 5'd31, 3'd0, 8'h08);
    wrTag(32'h0000_0800, 8'h0F);
    checkTuple("R4 bottom device bit", 8'h0, 5'd11, 3'd0, 8'h00);
  endtask

  task automatic t_error();
    wrTag(32'h0000_07FC, 8'h0F);
    checkEq("R5 errFlag set", {63'b0, errFlag}, 1);
    doAccess(DATA_OFF, 1'b0, 8'hFF, '0, 64'h5555, 0);
    checkEq("R5 no request on read", {63'b0, reqSeen}, 0);
    checkEq("R5 read returns all ones", rdOut, 64'hFFFF_FFFF_FFFF_FFFF);
    doAccess(DATA_OFF, 1'b1, 8'hFF, 64'h77, '0, 0);
    checkEq("R5 no request on write", {63'b0, reqSeen}, 0);
    wrTag(32'h0, 8'h0F);
    checkEq("R6 zero keeps errFlag", {63'b0, errFlag}, 1);
    rdTag("R6 zero stored", 32'h0);
    wrTag(32'h0000_1010, 8'h0F);
    checkEq("R4 errFlag cleared by good tag", {63'b0, errFlag}, 0);
  endtask

  task automatic t_zero();
    wrTag(32'h0012_1941, 8'h0F);
    wrTag(32'h0, 8'h0F);
    rdTag("R6 readback after zero", 32'h0);
    checkEq("R6 errFlag unchanged", {63'b0, errFlag}, 0);
    checkTuple("R6 tuple kept", 8'h12, 5'd3, 3'd1, 8'h40);
  endtask

  task automatic t_unmapped();
    doAccess(24'h400000, 1'b1, 8'hFF, 64'h55, '0, 0);
    checkEq("R9 no request at other offset", {63'b0, reqSeen}, 0);
    checkEq("R9 zero response", rdOut, 64'h0);
    doAccess(24'h400000, 1'b0, 8'hFF, '0, 64'h99, 0);
    checkEq("R9 read returns zero", rdOut, 64'h0);
    doAccess(TAG_OFF + 24'h4, 1'b1, 8'hFF, 64'h0000_0001_0000_0001, '0, 0);
    doAccess(TAG_OFF + 24'h1, 1'b1, 8'hFF, 64'h0000_0001_0000_0001, '0, 0);
    rdTag("R9 stored tag unchanged", 32'h0);
    doAccess(DATA_OFF + 24'h4, 1'b0, 8'hFF, '0, 64'h99, 0);
    checkEq("R9 misaligned data offset raises nothing", {63'b0, reqSeen}, 0);
    checkTuple("R9 tuple unchanged", 8'h12, 5'd3, 3'd1, 8'h40);
  endtask

  initial begin
    #(5 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_binary();
    t_partial();
    t_onehot();
    t_error();
    t_zero();
    t_unmapped();
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule